// File: doc/BRIEF.md
# Open-Drain Two-Wire Bus Master with Primitive Commands

This block is a master for a two-wire serial bus. Its clock line and data line are open drain: the block only pulls a line low or lets it go. Software or a sequencer above it builds each bus transaction from four single-step commands. These are: open the bus (or re-open it while it is still held), release the bus, shift one byte out and capture the answer from the slave, and shift one byte in and answer it with ACK or NACK.

Every accepted command ends with a one-cycle response that carries a two-bit result code. A read also returns the byte it received. Each bit takes four equal quarter periods of `QTR` system clocks: two with the clock line held low and two with it released.

A caller holds `cmd_valid` until `busy` rises, or pulses it while `busy` is low. It then waits for `rsp_valid`. The caller builds a whole transfer itself, for example: open, write the address byte, write data, release.

Top module: `i2c_prim_master`

## Requirements
- R1: After reset, both line enables are 0 (lines released), and `busy`, `bus_open`, `nack` and `rsp_valid` are 0. Whenever the block is neither busy nor holding the bus, both lines are released.
- R2: Opcode 0 produces one falling data edge while the clock line is high. If the bus is already held, the command first raises the data line while the clock is low, so no stop condition is produced; this is a repeated start. It completes with code 0 and `bus_open`=1.
- R3: Opcode 1 produces one rising data edge while the clock line is high and no falling one. It completes with code 0 and `bus_open`=0.
- R4: Opcode 2 sends `cmd_arg` most significant bit first over 9 clock pulses. During a byte command the data line changes only while the clock line is low.
- R5: If the data line is low at the 9th clock pulse of a write, the write completes with code 0 and `nack`=0. If the line is high, it completes with code 3 and `nack`=1. `nack` is cleared when the next command is accepted.
- R6: Opcode 3 samples 8 bits, most significant first, while the clock is high and returns them on `rsp_data` with code 0. `cmd_arg`=1 makes the master pull the data line low on the 9th pulse (ACK). `cmd_arg`=0 leaves the line released (NACK).
- R7: A read with `cmd_arg` greater than 1 completes with code 2 and produces no clock pulse.
- R8: Opcodes 4 to 7 complete with code 1 and produce no line activity.
- R9: A write or a read issued while `bus_open`=0 completes with code 3, produces no line activity and leaves `nack` at 0.
- R10: `busy` goes high on the edge that accepts a command and stays high until the response. A `cmd_valid` seen while `busy` is high has no effect.
- R11: `rsp_valid` is a one-cycle pulse, and `busy` is already low in that cycle. `rsp_data` is 0 for every command except a successful read.
- R12: During byte commands, every low and every high clock phase lasts exactly 2*`QTR` system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Opcode: 0 open, 1 release, 2 write byte, 3 read byte |
| cmd_arg | input | 8 | Byte to send (write) or ACK select (read) |
| sda_in | input | 1 | Level on the data line |
| busy | output | 1 | A command is in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_code | output | 2 | 0 done, 1 unknown opcode, 2 bad argument, 3 execution error |
| rsp_data | output | 8 | Byte received by a read |
| nack | output | 1 | The last write saw no acknowledge |
| bus_open | output | 1 | A transfer is open on the bus |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |

## Verification
Two things can happen in the same cycle: a new command can arrive at the moment the previous result is being delivered. The bench asserts a release request while an open command is still running and holds it up to and through the response pulse. It then checks three things. The open command must complete with the bus held and only one start condition. The held request must not have been taken early. It must be accepted on the edge right after the response, and it must then produce exactly one stop condition and a second response.

// File: rtl/i2c_prim_pkg.sv
package i2c_prim_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_W  = $clog2(BYTE_W + 1);

    localparam logic [2:0] OP_OPEN  = 3'd0;
    localparam logic [2:0] OP_CLOSE = 3'd1;
    localparam logic [2:0] OP_WRITE = 3'd2;
    localparam logic [2:0] OP_READ  = 3'd3;

    localparam logic [1:0] RC_DONE    = 2'd0;
    localparam logic [1:0] RC_UNKNOWN = 2'd1;
    localparam logic [1:0] RC_BADARG  = 2'd2;
    localparam logic [1:0] RC_EXEC    = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_CLOSE,
        ST_BYTE,
        ST_RESP
    } seq_e;

    typedef enum logic [2:0] {
        K_OPEN,
        K_CLOSE,
        K_WRITE,
        K_READ,
        K_REJECT
    } kind_e;

    typedef struct packed {
        seq_e              st;
        logic [1:0]        ph;
        logic [BIT_W-1:0]  bitn;
        logic [BYTE_W-1:0] sh;
        logic              rd;
        logic              ack_sel;
        logic              ack_seen;
        logic              scl_oe;
        logic              sda_oe;
        logic              open;
        logic              busy;
        logic              rsp_valid;
        logic [1:0]        rsp_code;
        logic [1:0]        pend_code;
        logic              pend_nack;
        logic [BYTE_W-1:0] rsp_data;
        logic              nack;
    } mst_t;

endpackage

// File: rtl/i2c_phase_tick.sv
module i2c_phase_tick #(
    parameter int QTR = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (QTR > 1) ? $clog2(QTR) : 1;
    localparam logic [CW-1:0] LAST = CW'(QTR - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run || cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/i2c_cmd_decode.sv
module i2c_cmd_decode
    import i2c_prim_pkg::*;
(
    input  logic              [2:0] op,
    input  logic       [BYTE_W-2:0] arg_hi,
    input  logic                    bus_open,
    output kind_e                   kind,
    output logic              [1:0] rej_code
);
    always_comb begin
        kind     = K_REJECT;
        rej_code = RC_UNKNOWN;
        case (op)
            OP_OPEN:  begin kind = K_OPEN;  rej_code = RC_DONE; end
            OP_CLOSE: begin kind = K_CLOSE; rej_code = RC_DONE; end
            OP_WRITE: begin
                if (bus_open) begin kind = K_WRITE; rej_code = RC_DONE; end
                else          rej_code = RC_EXEC;
            end
            OP_READ: begin
                if (|arg_hi)        rej_code = RC_BADARG;
                else if (!bus_open) rej_code = RC_EXEC;
                else begin kind = K_READ; rej_code = RC_DONE; end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/i2c_prim_master.sv
module i2c_prim_master
    import i2c_prim_pkg::*;
#(
    parameter int QTR = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [BYTE_W-1:0] cmd_arg,
    input  logic              sda_in,
    output logic              busy,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic [BYTE_W-1:0] rsp_data,
    output logic              nack,
    output logic              bus_open,
    output logic              scl_oe,
    output logic              sda_oe
);
    localparam logic [BIT_W-1:0] ACK_BIT = BIT_W'(BYTE_W);

    mst_t  q, n;
    kind_e kind;
    logic  [1:0] rej_code;
    logic  tick, run, adv, in_byte;

    assign run     = (q.st == ST_OPEN) || (q.st == ST_CLOSE) || (q.st == ST_BYTE);
    assign in_byte = (q.st == ST_BYTE);

    i2c_phase_tick #(.QTR(QTR)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .tick (tick)
    );

    i2c_cmd_decode u_dec (
        .op      (cmd_op),
        .arg_hi  (cmd_arg[BYTE_W-1:1]),
        .bus_open(q.open),
        .kind    (kind),
        .rej_code(rej_code)
    );

    always_comb begin
        n           = q;
        n.rsp_valid = 1'b0;
        adv         = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    n.busy      = 1'b1;
                    n.nack      = 1'b0;
                    n.pend_nack = 1'b0;
                    n.rsp_data  = '0;
                    n.ph        = 2'd0;
                    n.bitn      = '0;
                    adv         = 1'b1;
                    case (kind)
                        K_OPEN:  n.st = ST_OPEN;
                        K_CLOSE: n.st = ST_CLOSE;
                        K_WRITE: begin n.st = ST_BYTE; n.rd = 1'b0; n.sh = cmd_arg; end
                        K_READ:  begin n.st = ST_BYTE; n.rd = 1'b1; n.sh = '0;
                                       n.ack_sel = cmd_arg[0]; end
                        default: begin n.st = ST_RESP; n.pend_code = rej_code; adv = 1'b0; end
                    endcase
                end
            end
            ST_OPEN, ST_CLOSE: begin
                if (tick) begin
                    if (q.ph == 2'd3) begin
                        n.st        = ST_RESP;
                        n.pend_code = RC_DONE;
                        n.open      = (q.st == ST_OPEN);
                    end else begin
                        n.ph = q.ph + 2'd1;
                        adv  = 1'b1;
                    end
                end
            end
            ST_BYTE: begin
                if (tick) begin
                    if (q.ph == 2'd2) begin
                        if (q.bitn == ACK_BIT) begin
                            if (!q.rd) n.ack_seen = !sda_in;
                        end else if (q.rd) begin
                            n.sh = {q.sh[BYTE_W-2:0], sda_in};
                        end
                    end
                    if (q.ph == 2'd3) begin
                        if (q.bitn == ACK_BIT) begin
                            n.st = ST_RESP;
                            if (q.rd) begin
                                n.pend_code = RC_DONE;
                                n.rsp_data  = q.sh;
                            end else if (q.ack_seen) begin
                                n.pend_code = RC_DONE;
                            end else begin
                                n.pend_code = RC_EXEC;
                                n.pend_nack = 1'b1;
                            end
                        end else begin
                            if (!q.rd) n.sh = {q.sh[BYTE_W-2:0], 1'b0};
                            n.bitn = q.bitn + BIT_W'(1);
                            n.ph   = 2'd0;
                            adv    = 1'b1;
                        end
                    end else begin
                        n.ph = q.ph + 2'd1;
                        adv  = 1'b1;
                    end
                end
            end
            ST_RESP: begin
                n.st        = ST_IDLE;
                n.busy      = 1'b0;
                n.rsp_valid = 1'b1;
                n.rsp_code  = q.pend_code;
                n.nack      = q.pend_nack;
            end
            default: n.st = ST_IDLE;
        endcase

        // line levels for the phase being entered
        if (adv) begin
            case (n.st)
                ST_OPEN: begin
                    case (n.ph)
                        2'd0: n.scl_oe = q.open;
                        2'd1: n.sda_oe = 1'b0;
                        2'd2: n.scl_oe = 1'b0;
                        default: n.sda_oe = 1'b1;
                    endcase
                end
                ST_CLOSE: begin
                    case (n.ph)
                        2'd0: n.scl_oe = 1'b1;
                        2'd1: n.sda_oe = 1'b1;
                        2'd2: n.scl_oe = 1'b0;
                        default: n.sda_oe = 1'b0;
                    endcase
                end
                ST_BYTE: begin
                    case (n.ph)
                        2'd0: n.scl_oe = 1'b1;
                        2'd1: n.sda_oe = (n.bitn == ACK_BIT) ? (n.rd & n.ack_sel)
                                                             : (!n.rd & !n.sh[BYTE_W-1]);
                        2'd2: n.scl_oe = 1'b0;
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign busy      = q.busy;
    assign rsp_valid = q.rsp_valid;
    assign rsp_code  = q.rsp_code;
    assign rsp_data  = q.rsp_data;
    assign nack      = q.nack;
    assign bus_open  = q.open;
    assign scl_oe    = q.scl_oe;
    assign sda_oe    = q.sda_oe;
endmodule

// File: rtl/i2c_prim_master_chk.sv
module i2c_prim_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       rsp_valid,
    input logic [1:0] rsp_code,
    input logic       nack,
    input logic       bus_open,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       in_byte
);
    p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !bus_open) |-> (!scl_oe && !sda_oe));

    p_sda_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_byte && !scl_oe && $past(in_byte) && $past(!scl_oe)) |-> $stable(sda_oe));

    p_nack_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nack) |-> (rsp_valid && rsp_code == 2'd3));

    p_busy_until_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> rsp_valid);

    p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_rsp_not_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !busy);
endmodule

bind i2c_prim_master i2c_prim_master_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .rsp_valid(rsp_valid),
    .rsp_code (rsp_code),
    .nack     (nack),
    .bus_open (bus_open),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .in_byte  (in_byte)
);

// File: tb/sim_i2c_prim_master.sv
`timescale 1ns/1ps
module sim_i2c_prim_master;
    localparam int QTR  = 4;
    localparam int TCLK = 4;
    localparam int HALF_NS = 2 * QTR * TCLK;

    typedef struct packed {
        logic [2:0] op;
        logic [7:0] arg;
        logic       ack;
        logic [7:0] sdat;
        logic [1:0] code;
        logic [7:0] data;
        logic       open;
        logic       nk;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 8'h00, 1'b0, 8'h00, 2'd0, 8'h00, 1'b1, 1'b0},
        '{3'd2, 8'hA0, 1'b1, 8'h00, 2'd0, 8'h00, 1'b1, 1'b0},
        '{3'd2, 8'h00, 1'b1, 8'h00, 2'd0, 8'h00, 1'b1, 1'b0},
        '{3'd0, 8'h00, 1'b0, 8'h00, 2'd0, 8'h00, 1'b1, 1'b0},
        '{3'd2, 8'hA1, 1'b1, 8'h00, 2'd0, 8'h00, 1'b1, 1'b0},
        '{3'd3, 8'h00, 1'b0, 8'h11, 2'd0, 8'h11, 1'b1, 1'b0},
        '{3'd1, 8'h00, 1'b0, 8'h00, 2'd0, 8'h00, 1'b0, 1'b0},
        '{3'd2, 8'h55, 1'b1, 8'h00, 2'd3, 8'h00, 1'b0, 1'b0},
        '{3'd3, 8'h01, 1'b0, 8'h3C, 2'd3, 8'h00, 1'b0, 1'b0},
        '{3'd5, 8'h00, 1'b0, 8'h00, 2'd1, 8'h00, 1'b0, 1'b0},
        '{3'd0, 8'h00, 1'b0, 8'h00, 2'd0, 8'h00, 1'b1, 1'b0},
        '{3'd2, 8'h40, 1'b0, 8'h00, 2'd3, 8'h00, 1'b1, 1'b1},
        '{3'd3, 8'h02, 1'b0, 8'h77, 2'd2, 8'h00, 1'b1, 1'b0},
        '{3'd3, 8'h01, 1'b0, 8'hA5, 2'd0, 8'hA5, 1'b1, 1'b0},
        '{3'd7, 8'h00, 1'b0, 8'h00, 2'd1, 8'h00, 1'b1, 1'b0},
        '{3'd1, 8'h00, 1'b0, 8'h00, 2'd0, 8'h00, 1'b0, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [7:0] cmd_arg = '0;
    logic       busy, rsp_valid, nack, bus_open, scl_oe, sda_oe;
    logic [1:0] rsp_code;
    logic [7:0] rsp_data;
    logic       slave_pull = 1'b0;
    wire        scl_line = ~scl_oe;
    wire        sda_line = ~(sda_oe | slave_pull);

    always #2 clk = ~clk;

    i2c_prim_master #(.QTR(QTR)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .sda_in(sda_line), .busy(busy), .rsp_valid(rsp_valid),
        .rsp_code(rsp_code), .rsp_data(rsp_data), .nack(nack), .bus_open(bus_open),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    int n_chk = 0, n_fail = 0;
    int mode = 0;
    logic sl_ack = 1'b0;
    logic [7:0] sl_data = '0;
    int fall_tot = 0, fall_base = 0, rise_tot = 0, start_tot = 0, stop_tot = 0;
    int tim_bad = 0, rsp_tot = 0;
    logic [8:0] cap = '0;
    time t_fall = 0, t_rise = 0;

    // slave model: changes the data line only after a clock fall
    always @(negedge scl_line) begin
        int k;
        k = fall_tot - fall_base;
        if (mode == 1)      slave_pull <= (k == 8) && sl_ack;
        else if (mode == 2) slave_pull <= (k < 8) ? !sl_data[3'(7 - k)] : 1'b0;
        else                slave_pull <= 1'b0;
        if (mode != 0 && k >= 1 && ($time - t_rise) != HALF_NS) tim_bad++;
        t_fall = $time;
        fall_tot++;
    end

    always @(posedge scl_line) begin
        if (mode != 0 && ($time - t_fall) != HALF_NS) tim_bad++;
        t_rise = $time;
        rise_tot++;
        cap = {cap[7:0], sda_line};
    end

    always @(negedge sda_line) if (scl_line === 1'b1) start_tot++;
    always @(posedge sda_line) if (scl_line === 1'b1) stop_tot++;
    always @(posedge clk) if (rsp_valid) rsp_tot++;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [7:0] arg);
        cmd_op = op; cmd_arg = arg; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_rsp();
        int c = 0;
        while (rsp_valid !== 1'b1 && c < 4000) begin
            @(negedge clk);
            c++;
        end
        if (rsp_valid !== 1'b1) chk(1'b0, "R10", "response watchdog", 0, 1);
        else chk(busy == 1'b0, "R11", "busy low at response", busy, 0);
    endtask

    task automatic after_rsp();
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R11", "single-cycle response", rsp_valid, 0);
    endtask

    initial begin
        #600000;
        n_chk++; n_fail++;
        $display("FAIL R10 global watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R1", "lines released", {scl_oe, sda_oe}, 0);
        chk(busy == 1'b0 && bus_open == 1'b0, "R1", "busy/open", {busy, bus_open}, 0);
        chk(nack == 1'b0 && rsp_valid == 1'b0, "R1", "nack/rsp", {nack, rsp_valid}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(scl_oe == 1'b0 && sda_oe == 1'b0 && busy == 1'b0, "R1", "idle after reset",
            {scl_oe, sda_oe, busy}, 0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            bit ob, act;
            int r0, s0, p0, t0, exp_r;
            string rq;
            v  = VEC[i];
            ob = bus_open;
            act = (v.op == 3'd0) || (v.op == 3'd1) ||
                  (((v.op == 3'd2) || (v.op == 3'd3)) && ob && !(v.op == 3'd3 && v.arg > 8'd1));
            if (v.op == 3'd0)      rq = "R2";
            else if (v.op == 3'd1) rq = "R3";
            else if (v.op > 3'd3)  rq = "R8";
            else if (v.op == 3'd3 && v.arg > 8'd1) rq = "R7";
            else if (!ob)          rq = "R9";
            else if (v.op == 3'd2) rq = "R5";
            else                   rq = "R6";
            mode    = !act ? 0 : (v.op == 3'd2) ? 1 : (v.op == 3'd3) ? 2 : 0;
            sl_ack  = v.ack;
            sl_data = v.sdat;
            fall_base = fall_tot;
            r0 = rise_tot; s0 = start_tot; p0 = stop_tot; t0 = tim_bad;
            issue(v.op, v.arg);
            chk(busy == 1'b1, "R10", "busy after accept", busy, 1);
            wait_rsp();
            chk(rsp_code == v.code, rq, "result code", rsp_code, v.code);
            chk(rsp_data == v.data, (v.op == 3'd3) ? "R6" : "R11", "returned byte", rsp_data, v.data);
            chk(bus_open == v.open, rq, "bus open flag", bus_open, v.open);
            chk(nack == v.nk, (v.op == 3'd2 && ob) ? "R5" : "R9", "nack flag", nack, v.nk);
            exp_r = !act ? 0 : (v.op == 3'd0) ? (ob ? 1 : 0) : (v.op == 3'd1) ? 1 : 9;
            chk(rise_tot - r0 == exp_r, rq, "clock pulses", rise_tot - r0, exp_r);
            chk(start_tot - s0 == ((act && v.op == 3'd0) ? 1 : 0), (v.op > 3'd1) ? "R4" : rq,
                "start conditions", start_tot - s0, (act && v.op == 3'd0) ? 1 : 0);
            chk(stop_tot - p0 == ((act && v.op == 3'd1) ? 1 : 0), (v.op > 3'd1) ? "R4" : rq,
                "stop conditions", stop_tot - p0, (act && v.op == 3'd1) ? 1 : 0);
            if (act && v.op == 3'd2) begin
                chk(cap[8:1] == v.arg, "R4", "bits on the wire", cap[8:1], v.arg);
                chk(cap[0] == !v.ack, "R5", "ninth bit level", cap[0], !v.ack);
            end
            if (act && v.op == 3'd3)
                chk(cap[0] == !v.arg[0], "R6", "master answer on ninth bit", cap[0], !v.arg[0]);
            if (mode != 0)
                chk(tim_bad == t0, "R12", "clock phase length", tim_bad - t0, 0);
            after_rsp();
            mode = 0;
        end

        // collision: request held through the response of the running command
        begin
            int rs0, s0, p0;
            rs0 = rsp_tot; s0 = start_tot; p0 = stop_tot;
            issue(3'd0, 8'h00);
            cmd_op = 3'd1; cmd_valid = 1'b1;
            wait_rsp();
            chk(bus_open == 1'b1 && rsp_code == 2'd0, "R10", "open finished before held request",
                {bus_open, rsp_code}, 4);
            @(negedge clk);
            cmd_valid = 1'b0;
            chk(busy == 1'b1, "R10", "held request taken after response", busy, 1);
            wait_rsp();
            chk(bus_open == 1'b0 && rsp_code == 2'd0, "R3", "release after collision",
                {bus_open, rsp_code}, 0);
            after_rsp();
            repeat (40) @(negedge clk);
            chk(rsp_tot - rs0 == 2, "R10", "response count", rsp_tot - rs0, 2);
            chk(start_tot - s0 == 1 && stop_tot - p0 == 1, "R10", "conditions in collision",
                (start_tot - s0) * 16 + (stop_tot - p0), 17);
            chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R1", "released when idle", {scl_oe, sda_oe}, 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule